// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This bridge sits behind a 32 MB alias window on the system bus. Each 32-bit word of the window stands for one bit of a 1 MB backing region. A requester reads or writes a single bit by touching its alias word. The bridge turns every accepted slave request into one or two accesses on a simple command/completion master port toward the backing memory.

A read fetches the backing unit at the access size (byte, halfword or word) and answers 1 or 0. A write is a read-modify-write: the bridge fetches the unit, sets or clears one bit from bit 0 of the write data, and writes the unit back at the same address and size. The slave response is held until the backing write completes, so the requester sees the update as atomic.

The backing base is a parameter. Typical instances are SRAM at 0x20000000 behind an alias at 0x22000000, and peripherals at 0x40000000 behind an alias at 0x42000000. Only the low 25 alias address bits are decoded.

The controller has six states: IDLE, RD, WAIT_RD, WR, WAIT_WR and RESP. Its transitions are:
- IDLE to RD on an accepted request.
- RD to WAIT_RD unconditionally.
- WAIT_RD to WR on completion when the request is a write.
- WAIT_RD to RESP on completion when the request is a read.
- WR to WAIT_WR unconditionally.
- WAIT_WR to RESP on completion.
- RESP to IDLE unconditionally.

Top module: `bitband_bridge`

## Requirements
- R1: After reset, s_ready and m_req are both low, and the bridge accepts a new request.
- R2: The backing address is BASE OR (alias[24:0] >> 5). For halfword accesses bit 0 is then cleared, and for word accesses bits 1:0 are cleared. s_size encodes 0 as byte, 1 as halfword, and 2 or 3 as word; m_size carries 0, 1 or 2.
- R3: The selected bit index is alias[4:2] for a byte, alias[5:2] for a halfword, and alias[6:2] for a word. Bit n counts from bit 0 of the little-endian unit.
- R4: A read issues exactly one backing read. It returns 1 in s_rdata bit 0 when the selected bit is set and 0 otherwise, and s_rdata bits 31:1 are always zero.
- R5: A write issues a backing read, then a backing write to the same address at the same size. The written unit equals the fetched unit with only the selected bit replaced by s_wdata[0]. s_wdata bits 31:1 have no effect.
- R6: s_ready is a one-cycle pulse. It comes after the backing read completes for a read, and after the backing write completes for a write. A write response carries s_rdata = 0.
- R7: s_req is ignored from acceptance until the response pulse. Such a request produces no response and changes no memory.
- R8: m_req is high for exactly one cycle per backing command. m_ready counts only while waiting for a command. The write command never precedes the completion of its read.
- R9: Backing units are right-aligned on m_rdata and m_wdata. m_rdata bits above the unit width are ignored, and m_wdata bits above the unit width are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_req | input | 1 | Slave request, sampled in IDLE |
| s_we | input | 1 | Slave write enable |
| s_size | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| s_addr | input | 32 | Alias address |
| s_wdata | input | 32 | Write data; bit 0 is the new bit value |
| s_ready | output | 1 | One-cycle response pulse |
| s_rdata | output | 32 | Zero-extended bit value |
| m_req | output | 1 | One-cycle backing command |
| m_we | output | 1 | Backing command is a write |
| m_size | output | 2 | Backing unit size |
| m_addr | output | 32 | Backing byte address |
| m_wdata | output | 32 | Right-aligned unit to write |
| m_rdata | input | 32 | Right-aligned unit read |
| m_ready | input | 1 | Backing command completion pulse |

## Verification
A wrong captured offset or size shows on m_addr or m_size at the very first backing command, one cycle after acceptance. A stale or miscaptured read unit appears as extra bits flipping in the unit written back, and it is visible on m_wdata in the WR cycle. A state machine that skips a wait or leaves RESP early shows as a missing, doubled or early s_ready. It can also show as a write command issued before its read completed, and this appears within a few cycles of the backing completion.

// File: rtl/bb_pkg.sv
package bb_pkg;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_WAIT_RD,
        ST_WR,
        ST_WAIT_WR,
        ST_RESP
    } bb_state_t;

    function automatic logic [31:0] unit_mask(input logic [1:0] sz);
        unique case (sz)
            SZ_BYTE: unit_mask = 32'h0000_00FF;
            SZ_HALF: unit_mask = 32'h0000_FFFF;
            default: unit_mask = 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/bb_addr_map.sv
module bb_addr_map
    import bb_pkg::*;
#(
    parameter int          OFF_W = 25,
    parameter logic [31:0] BASE  = 32'h2000_0000
) (
    input  logic [OFF_W-1:0] off,
    input  logic [1:0]       size,
    output logic [31:0]      baddr,
    output logic [4:0]       bit_idx
);
    localparam int BACK_W = OFF_W - 5;

    logic [31:0] raw;
    assign raw = BASE | {{(32-BACK_W){1'b0}}, off[OFF_W-1:5]};

    always_comb begin
        unique case (size)
            SZ_BYTE: begin
                baddr   = raw;
                bit_idx = {2'b00, off[4:2]};
            end
            SZ_HALF: begin
                baddr   = {raw[31:1], 1'b0};
                bit_idx = {1'b0, off[5:2]};
            end
            default: begin
                baddr   = {raw[31:2], 2'b00};
                bit_idx = off[6:2];
            end
        endcase
    end
endmodule

// File: rtl/bb_bit_op.sv
module bb_bit_op
    import bb_pkg::*;
(
    input  logic [31:0] unit_in,
    input  logic [1:0]  size,
    input  logic [4:0]  bit_idx,
    input  logic        new_val,
    output logic        bit_out,
    output logic [31:0] unit_out
);
    logic [31:0] clean;
    logic [31:0] sel;

    assign clean    = unit_in & unit_mask(size);
    assign sel      = 32'd1 << bit_idx;
    assign bit_out  = |(clean & sel);
    assign unit_out = new_val ? (clean | sel) : (clean & ~sel);
endmodule

// File: rtl/bb_fsm.sv
module bb_fsm
    import bb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      s_req,
    input  logic      we_q,
    input  logic      m_ready,
    output bb_state_t state,
    output logic      accept,
    output logic      cap_rd,
    output logic      m_req,
    output logic      m_we,
    output logic      s_ready
);
    bb_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (s_req) state_d = ST_RD;
            ST_RD:      state_d = ST_WAIT_RD;
            ST_WAIT_RD: if (m_ready) state_d = we_q ? ST_WR : ST_RESP;
            ST_WR:      state_d = ST_WAIT_WR;
            ST_WAIT_WR: if (m_ready) state_d = ST_RESP;
            ST_RESP:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        accept  = (state_q == ST_IDLE) && s_req;
        cap_rd  = (state_q == ST_WAIT_RD) && m_ready;
        m_req   = (state_q == ST_RD) || (state_q == ST_WR);
        m_we    = (state_q == ST_WR);
        s_ready = (state_q == ST_RESP);
    end

    assign state = state_q;

    // R8
    one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_req |=> !m_req);

    // R8
    wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && m_we) |-> $past(m_ready));

    // R6
    resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |=> !s_ready);

    // R7
    no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_req && !accept) |=> !m_req || m_we || $past(state == ST_IDLE));
endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
    import bb_pkg::*;
#(
    parameter int          OFF_W = 25,
    parameter logic [31:0] BASE  = 32'h2000_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        s_req,
    input  logic        s_we,
    input  logic [1:0]  s_size,
    input  logic [31:0] s_addr,
    input  logic [31:0] s_wdata,
    output logic        s_ready,
    output logic [31:0] s_rdata,
    output logic        m_req,
    output logic        m_we,
    output logic [1:0]  m_size,
    output logic [31:0] m_addr,
    output logic [31:0] m_wdata,
    input  logic [31:0] m_rdata,
    input  logic        m_ready
);
    localparam int BACK_W = OFF_W - 5;

    bb_state_t        state;
    logic             accept, cap_rd;
    logic [OFF_W-1:0] off_q;
    logic [1:0]       size_q;
    logic             we_q, val_q;
    logic [31:0]      rd_q;
    logic [4:0]       bit_idx;
    logic             bit_val;

    logic unused_bits;
    assign unused_bits = ^{s_wdata[31:1], s_addr[31:OFF_W]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q  <= '0;
            size_q <= SZ_BYTE;
            we_q   <= 1'b0;
            val_q  <= 1'b0;
            rd_q   <= '0;
        end else begin
            if (accept) begin
                off_q  <= s_addr[OFF_W-1:0];
                size_q <= (s_size == 2'd3) ? SZ_WORD : s_size;
                we_q   <= s_we;
                val_q  <= s_wdata[0];
            end
            if (cap_rd) rd_q <= m_rdata;
        end
    end

    bb_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .s_req   (s_req),
        .we_q    (we_q),
        .m_ready (m_ready),
        .state   (state),
        .accept  (accept),
        .cap_rd  (cap_rd),
        .m_req   (m_req),
        .m_we    (m_we),
        .s_ready (s_ready)
    );

    bb_addr_map #(.OFF_W(OFF_W), .BASE(BASE)) u_map (
        .off     (off_q),
        .size    (size_q),
        .baddr   (m_addr),
        .bit_idx (bit_idx)
    );

    bb_bit_op u_bit (
        .unit_in  (rd_q),
        .size     (size_q),
        .bit_idx  (bit_idx),
        .new_val  (val_q),
        .bit_out  (bit_val),
        .unit_out (m_wdata)
    );

    assign m_size  = size_q;
    assign s_rdata = {31'd0, bit_val & ~we_q & s_ready};

    // R5
    single_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && m_we) |-> $onehot0((m_wdata ^ rd_q) & unit_mask(m_size)));

    // R2
    in_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_req |-> (m_addr[31:BACK_W] == BASE[31:BACK_W]));

    // R5
    same_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && m_we) |-> (state == ST_WR) && $stable(m_addr) && $stable(m_size));

    // R9
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && m_we) |-> ((m_wdata & ~unit_mask(m_size)) == 32'd0));
endmodule

// File: tb/tb_bitband_bridge.sv
module tb_bitband_bridge;
    localparam logic [31:0] BASE  = 32'h2000_0000;
    localparam logic [31:0] ALIAS = 32'h2200_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_req = 1'b0, s_we = 1'b0;
    logic [1:0]  s_size = 2'd0;
    logic [31:0] s_addr = '0, s_wdata = '0;
    logic        s_ready;
    logic [31:0] s_rdata;
    logic        m_req, m_we;
    logic [1:0]  m_size;
    logic [31:0] m_addr, m_wdata;
    logic [31:0] m_rdata = '0;
    logic        m_ready = 1'b0;

    always #10 clk = ~clk;

    bitband_bridge #(.OFF_W(25), .BASE(BASE)) dut (
        .clk(clk), .rst_n(rst_n),
        .s_req(s_req), .s_we(s_we), .s_size(s_size), .s_addr(s_addr),
        .s_wdata(s_wdata), .s_ready(s_ready), .s_rdata(s_rdata),
        .m_req(m_req), .m_we(m_we), .m_size(m_size), .m_addr(m_addr),
        .m_wdata(m_wdata), .m_rdata(m_rdata), .m_ready(m_ready)
    );

    int checks = 0, failures = 0;
    bit finished = 0;

    logic [7:0] mem [int];
    logic [7:0] ref_mem [int];
    int touched [$];

    logic [31:0] exp_q [$];
    string       tag_q [$];
    int          resp_cnt = 0;

    logic [31:0] exp_addr;
    logic [1:0]  exp_size;
    bit          exp_we;
    int          req_no;
    bit          prev_ready = 0, prev_mreq = 0;
    bit          busy = 0;
    int          cnt = 0, lat_ctr = 0;
    logic [31:0] pend_data;

    function automatic logic [7:0] init_byte(int a);
        return 8'((a * 37 + 5) ^ (a >> 8));
    endfunction

    function automatic logic [7:0] mem_get(int a);
        return mem.exists(a) ? mem[a] : init_byte(a);
    endfunction

    function automatic logic [7:0] ref_get(int a);
        return ref_mem.exists(a) ? ref_mem[a] : init_byte(a);
    endfunction

    function automatic int nbytes(logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [31:0] szmask(logic [1:0] sz);
        return (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // backing memory model: one-cycle commands, completion after variable latency
    always @(negedge clk) begin
        m_ready <= 1'b0;
        if (busy) begin
            if (cnt == 0) begin
                m_ready <= 1'b1;
                m_rdata <= pend_data;
                busy <= 0;
            end else cnt <= cnt - 1;
        end
        if (rst_n && m_req) begin
            // R8 single-cycle command
            check("R8 m_req single cycle", 32'(prev_mreq), 32'd0);
            check("R2 backing address", m_addr, exp_addr);
            check("R2 backing size", 32'(m_size), 32'(exp_size));
            check("R5 command order", 32'(m_we), 32'(req_no == 1));
            if (!exp_we) check("R4 single backing read", 32'(req_no), 32'd0);
            if (m_we) begin
                // R9 upper bits zero
                check("R9 m_wdata upper bits", m_wdata & ~szmask(m_size), 32'd0);
                for (int i = 0; i < nbytes(m_size); i++)
                    mem[int'(m_addr) + i] = m_wdata[8*i +: 8];
                pend_data = 32'hDEAD_BEEF;
            end else begin
                pend_data = 32'hA5A5_A5A5 & ~szmask(m_size);
                for (int i = 0; i < nbytes(m_size); i++)
                    pend_data[8*i +: 8] = mem_get(int'(m_addr) + i);
            end
            req_no = req_no + 1;
            busy <= 1;
            cnt <= lat_ctr % 3;
            lat_ctr = lat_ctr + 1;
        end
        prev_mreq = rst_n && m_req;
    end

    // monitor: pops the expected response for each s_ready pulse
    always @(negedge clk) begin
        if (rst_n && s_ready) begin
            check("R6 s_ready pulse width", 32'(prev_ready), 32'd0);
            if (exp_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL R7 unexpected response actual=%h expected=none", s_rdata);
            end else begin
                check(tag_q.pop_front(), s_rdata, exp_q.pop_front());
            end
            resp_cnt++;
        end
        prev_ready = rst_n && s_ready;
    end

    task automatic access(bit we, logic [1:0] size, logic [31:0] addr,
                          logic [31:0] wdata, string tag, bit intrude);
        logic [24:0] off;
        logic [31:0] raw, baddr, unit, eunit;
        logic [1:0]  nsz;
        int          idx, start;
        off = addr[24:0];
        raw = BASE | 32'(off >> 5);
        nsz = (size == 2'd3) ? 2'd2 : size;
        case (nsz)
            2'd0: begin baddr = raw;                idx = int'(off[4:2]); end
            2'd1: begin baddr = {raw[31:1], 1'b0};  idx = int'(off[5:2]); end
            default: begin baddr = {raw[31:2], 2'b00}; idx = int'(off[6:2]); end
        endcase
        unit = '0;
        for (int i = 0; i < nbytes(nsz); i++) unit[8*i +: 8] = ref_get(int'(baddr) + i);
        if (we) begin
            eunit = unit;
            eunit[idx] = wdata[0];
            for (int i = 0; i < nbytes(nsz); i++) begin
                ref_mem[int'(baddr) + i] = eunit[8*i +: 8];
                touched.push_back(int'(baddr) + i);
            end
            exp_q.push_back(32'd0);
        end else begin
            exp_q.push_back({31'd0, unit[idx]});
        end
        tag_q.push_back(tag);
        exp_addr = baddr; exp_size = nsz; exp_we = we; req_no = 0;
        start = resp_cnt;
        @(negedge clk);
        s_req = 1; s_we = we; s_size = size; s_addr = addr; s_wdata = wdata;
        @(negedge clk);
        s_req = 0;
        if (intrude) begin
            // R7: request while busy must be ignored
            s_req = 1; s_we = 1; s_size = 2'd2; s_addr = ALIAS + 32'h40; s_wdata = 32'h1;
            @(negedge clk);
            s_req = 0;
            @(negedge clk);
            s_req = 1;
            @(negedge clk);
            s_req = 0;
        end
        while (resp_cnt == start) @(negedge clk);
        @(negedge clk);
        check({tag, " command count"}, 32'(req_no), we ? 32'd2 : 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 s_ready in reset", 32'(s_ready), 32'd0);
        check("R1 m_req in reset", 32'(m_req), 32'd0);
        rst_n = 1;
        @(negedge clk);
        check("R1 s_ready after reset", 32'(s_ready), 32'd0);
        check("R1 m_req after reset", 32'(m_req), 32'd0);

        // R2 R3 R4 reads, various sizes and offsets
        for (int b = 0; b < 8; b++)
            access(0, 2'd0, ALIAS + (32'h100 << 5) + 32'(b << 2), 32'h0, "R3 byte read bit", 0);
        for (int b = 0; b < 16; b += 5)
            access(0, 2'd1, ALIAS + (32'h246 << 5) + 32'(b << 2), 32'h0, "R3 half read bit", 0);
        for (int b = 0; b < 32; b += 7)
            access(0, 2'd2, ALIAS + (32'h1357 << 5) + 32'(b << 2), 32'h0, "R4 word read bit", 0);
        access(0, 2'd3, ALIAS + 32'h01FF_FFFC, 32'h0, "R2 size3 top of window", 0);
        access(0, 2'd0, 32'h4200_0000 + 32'h0000_0020, 32'h0, "R2 upper alias bits ignored", 0);

        // R5 writes: set and clear, all sizes, other data bits ignored
        access(1, 2'd0, ALIAS + (32'h200 << 5) + (32'd3 << 2), 32'h1, "R5 byte set", 0);
        access(0, 2'd0, ALIAS + (32'h200 << 5) + (32'd3 << 2), 32'h0, "R5 byte set readback", 0);
        access(1, 2'd1, ALIAS + (32'h300 << 5) + (32'd13 << 2), 32'hFFFF_FFFE, "R5 half clear data ignored", 0);
        access(0, 2'd1, ALIAS + (32'h300 << 5) + (32'd13 << 2), 32'h0, "R5 half clear readback", 0);
        access(1, 2'd2, ALIAS + (32'h400 << 5) + (32'd31 << 2), 32'h8000_0001, "R5 word set bit31", 0);
        access(0, 2'd2, ALIAS + (32'h400 << 5) + (32'd31 << 2), 32'h0, "R5 word readback", 0);
        access(0, 2'd0, ALIAS + (32'h403 << 5) + (32'd7 << 2), 32'h0, "R3 little-endian alias", 0);
        access(1, 2'd2, ALIAS + (32'h400 << 5) + (32'd0 << 2), 32'h0, "R6 write response zero", 0);

        // R7 request during busy ignored
        access(1, 2'd0, ALIAS + (32'h500 << 5), 32'h1, "R7 busy write", 1);
        access(0, 2'd2, ALIAS + 32'h40, 32'h0, "R7 intruder left no trace", 0);
        check("R6 response count", 32'(exp_q.size()), 32'd0);

        // R5 R9 memory compare: only selected bits changed
        foreach (touched[i])
            check("R5 backing memory", 32'(mem_get(touched[i])), 32'(ref_get(touched[i])));

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule